// File: doc/BRIEF.md
# Frequency Lock Monitor for a Clock-Recovery Loop

This block watches the oscillator of a clock-recovery loop and decides whether its frequency is close enough to the expected line rate for the phase loop to take over. It counts edges of a divided oscillator clock over a window timed by the reference clock, compares the count with the count a correct frequency would give, and drives an active-high loss-of-lock flag. The flag has asymmetric hysteresis: it clears only when the error is within 500 ppm and sets again only when the error exceeds 1000 ppm. Between the two limits it keeps its previous value. That lets the flag cycle on its own when there is no input data: the oscillator drifts out, the frequency loop takes over, pulls it back, and hands control back again.

The reference may run at one of four frequencies (19.44, 38.88, 77.76 or 155.52 MHz, chosen by a 2-bit code), and the line rate is either native or 15/14 of native, with the same reference for both. The window length scales with the reference code so that the expected count, and with it the resolution, does not depend on the reference chosen. The oscillator count is moved into the reference domain by a toggle handshake. A watchdog in the oscillator domain raises the flag when reference edges stop arriving. The second output tells the loop which path steers the oscillator.

Top module: `lkd_freq_lock`

## Requirements
- R1: After reset, lock_lost is 1 and stays 1 until a baseline capture has been taken and one further full window has been measured and judged.
- R2: When a judged window's count differs from the expected count by no more than LO (floor of expected × 500 / 10^6), lock_lost goes to 0.
- R3: When a judged window's count differs from the expected count by more than HI (floor of expected × 1000 / 10^6), in either direction, lock_lost goes to 1.
- R4: When the difference lies above LO and at most HI, lock_lost keeps its previous value, whether that value is 0 or 1.
- R5: phase_loop_sel is the inverse of lock_lost: 1 hands the oscillator to the phase loop, 0 keeps it on the frequency loop.
- R6: The window lasts BASE_WIN << ref_sel reference cycles, with ref_sel 00, 01, 10 and 11 meaning 19.44, 38.88, 77.76 and 155.52 MHz. At the native rate the expected count is BASE_WIN × VCO_MULT, so a reference that does not match its code is seen as loss of lock.
- R7: With fec_rate = 1 the expected count is floor(BASE_WIN × VCO_MULT × 15 / 14). An oscillator at the native rate is then out of lock, and one at 15/14 of native is in lock.
- R8: Any change of ref_sel or fec_rate sets lock_lost to 1 at once, restarts the window and discards any capture in flight. A new baseline and a full judged window are then needed before the flag can clear.
- R9: If no reference activity reaches the oscillator domain for DEAD_LIM oscillator cycles, lock_lost is 1. It clears again once the reference resumes and a good window is judged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock; times the measurement window |
| vco_div_clk | input | 1 | Divided oscillator clock being measured |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| ref_sel | input | 2 | Reference frequency code |
| fec_rate | input | 1 | 0 = native line rate, 1 = 15/14 rate |
| lock_lost | output | 1 | Active-high loss-of-lock flag |
| phase_loop_sel | output | 1 | 1 = phase loop steers the oscillator, 0 = frequency loop |

## Verification
The bench places the oscillator period in each band of the hysteresis: well inside 500 ppm, between the limits, and beyond 1000 ppm on both the fast and the slow side. It then checks that the band between the limits keeps both a set and a cleared flag. A design with one threshold, or with the limits swapped, would clear or set there. It checks every reference code with a matching reference clock and one code with a mismatched clock, so a wrong window length shows up as a false lock or a missed loss. A design that ignored the rate select would lock on the native oscillator when the 15/14 rate is selected. The bench also checks that the flag stays high for the first half window after reset and after a configuration change, so a design that judged its first partial count would release too early. Stopping the reference clock must raise the flag, because the reference-domain logic freezes with its last value and cannot report the loss itself.

// File: rtl/lkd_pkg.sv
`timescale 1ps/1ps
package lkd_pkg;

    typedef enum logic [1:0] {
        ST_FLUSH = 2'd0,   // waiting for first window edge after (re)start
        ST_BASE  = 2'd1,   // baseline capture requested
        ST_RUN   = 2'd2    // every capture is judged
    } lkd_stage_e;

    // Expected divided-oscillator count per window for a rate choice.
    function automatic int unsigned lkd_expect(int unsigned base_win,
                                               int unsigned mult,
                                               logic        fec);
        int unsigned nat;
        nat = base_win * mult;
        return fec ? (nat * 15) / 14 : nat;
    endfunction

    // Count tolerance for a ppm limit, rounded down.
    function automatic int unsigned lkd_ppm(int unsigned cnt, int unsigned ppm);
        return (cnt * ppm) / 1000000;
    endfunction

endpackage

// File: rtl/lkd_vco_side.sv
`timescale 1ps/1ps
module lkd_vco_side #(
    parameter int CNT_W    = 16,
    parameter int DEAD_LIM = 256
) (
    input  logic             vco_clk,
    input  logic             rst_n,
    input  logic             req_tgl_i,
    input  logic             hb_i,
    output logic [CNT_W-1:0] hold_o,
    output logic             ack_tgl_o,
    output logic             dead_o
);
    localparam int DOG_W = $clog2(DEAD_LIM + 1);
    localparam logic [DOG_W-1:0] DOG_MAX = DOG_W'(DEAD_LIM);

    typedef struct packed {
        logic             req_s1;
        logic             req_s2;
        logic             req_seen;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] hold;
        logic             ack;
        logic             hb_s1;
        logic             hb_s2;
        logic             hb_prev;
        logic [DOG_W-1:0] dog;
        logic             dead;
    } vco_st_t;

    vco_st_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.req_s1 = req_tgl_i;
        st_d.req_s2 = st_q.req_s1;
        st_d.cnt    = st_q.cnt + CNT_W'(1);
        if (st_q.req_s2 != st_q.req_seen) begin
            st_d.req_seen = st_q.req_s2;
            st_d.hold     = st_q.cnt;
            st_d.ack      = ~st_q.ack;
        end
        st_d.hb_s1   = hb_i;
        st_d.hb_s2   = st_q.hb_s1;
        st_d.hb_prev = st_q.hb_s2;
        if (st_q.hb_s2 != st_q.hb_prev)
            st_d.dog = '0;
        else if (st_q.dog != DOG_MAX)
            st_d.dog = st_q.dog + DOG_W'(1);
        st_d.dead = (st_q.dog == DOG_MAX);
    end

    always_ff @(posedge vco_clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign hold_o    = st_q.hold;
    assign ack_tgl_o = st_q.ack;
    assign dead_o    = st_q.dead;

    // The holding register may only move when a capture request arrives (R6)
    assert_hold_steady_R6: assert property (@(posedge vco_clk) disable iff (!rst_n)
        (st_q.req_s2 == st_q.req_seen) |=> $stable(st_q.hold));

    // A quiet reference for the full limit leads to the dead indication (R9)
    assert_ref_dead_R9: assert property (@(posedge vco_clk) disable iff (!rst_n)
        (st_q.dog == DOG_MAX && st_q.hb_s2 == st_q.hb_prev) |=> st_q.dead);

    // Any reference activity clears the dead indication (R9)
    assert_ref_alive_R9: assert property (@(posedge vco_clk) disable iff (!rst_n)
        (st_q.hb_s2 != st_q.hb_prev) |=> ##1 !st_q.dead);
endmodule

// File: rtl/lkd_ref_side.sv
`timescale 1ps/1ps
module lkd_ref_side
    import lkd_pkg::*;
#(
    parameter int BASE_WIN = 512,
    parameter int VCO_MULT = 8,
    parameter int CNT_W    = 16,
    parameter int PPM_REL  = 500,
    parameter int PPM_SET  = 1000
) (
    input  logic             ref_clk,
    input  logic             rst_n,
    input  logic [1:0]       ref_sel,
    input  logic             fec_rate,
    input  logic [CNT_W-1:0] hold_i,
    input  logic             ack_tgl_i,
    output logic             req_tgl_o,
    output logic             hb_o,
    output logic             flag_o
);
    localparam int WIN_W = $clog2(BASE_WIN) + 4;
    localparam int unsigned EXP_N = lkd_expect(BASE_WIN, VCO_MULT, 1'b0);
    localparam int unsigned EXP_F = lkd_expect(BASE_WIN, VCO_MULT, 1'b1);
    localparam logic [CNT_W+1:0] EXP_N_V = (CNT_W+2)'(EXP_N);
    localparam logic [CNT_W+1:0] EXP_F_V = (CNT_W+2)'(EXP_F);
    localparam logic [CNT_W+1:0] LO_N = (CNT_W+2)'(lkd_ppm(EXP_N, PPM_REL));
    localparam logic [CNT_W+1:0] HI_N = (CNT_W+2)'(lkd_ppm(EXP_N, PPM_SET));
    localparam logic [CNT_W+1:0] LO_F = (CNT_W+2)'(lkd_ppm(EXP_F, PPM_REL));
    localparam logic [CNT_W+1:0] HI_F = (CNT_W+2)'(lkd_ppm(EXP_F, PPM_SET));

    typedef struct packed {
        logic [WIN_W-1:0] win;
        logic             req;
        logic             ack_s1;
        logic             ack_s2;
        logic             ack_seen;
        logic [CNT_W-1:0] base;
        lkd_stage_e       stage;
        logic             flag;
        logic [1:0]       sel;
        logic             rate;
    } ref_st_t;

    ref_st_t st_d, st_q;

    logic                    cfg_chg;
    logic                    win_end;
    logic                    ack_evt;
    logic [WIN_W-1:0]        win_len;
    logic [CNT_W-1:0]        meas;
    logic signed [CNT_W+1:0] diff;
    logic [CNT_W+1:0]        abs_err;
    logic [CNT_W+1:0]        lo_lim;
    logic [CNT_W+1:0]        hi_lim;

    always_comb begin
        cfg_chg = (ref_sel != st_q.sel) || (fec_rate != st_q.rate);
        win_len = WIN_W'(BASE_WIN) << st_q.sel;
        win_end = (st_q.win == win_len - WIN_W'(1));
        ack_evt = (st_q.ack_s2 != st_q.ack_seen);
        meas    = hold_i - st_q.base;
        diff    = $signed({2'b00, meas}) - $signed(st_q.rate ? EXP_F_V : EXP_N_V);
        abs_err = diff[CNT_W+1] ? $unsigned(-diff) : $unsigned(diff);
        lo_lim  = st_q.rate ? LO_F : LO_N;
        hi_lim  = st_q.rate ? HI_F : HI_N;

        st_d          = st_q;
        st_d.ack_s1   = ack_tgl_i;
        st_d.ack_s2   = st_q.ack_s1;
        st_d.ack_seen = st_q.ack_s2;

        if (cfg_chg) begin
            st_d.sel   = ref_sel;
            st_d.rate  = fec_rate;
            st_d.win   = '0;
            st_d.stage = ST_FLUSH;
            st_d.flag  = 1'b1;
        end else begin
            st_d.win = win_end ? '0 : st_q.win + WIN_W'(1);
            if (win_end) begin
                st_d.req = ~st_q.req;
                if (st_q.stage == ST_FLUSH) st_d.stage = ST_BASE;
            end
            if (ack_evt) begin
                unique case (st_q.stage)
                    ST_BASE: begin
                        st_d.base  = hold_i;
                        st_d.stage = ST_RUN;
                    end
                    ST_RUN: begin
                        st_d.base = hold_i;
                        if (abs_err > hi_lim)       st_d.flag = 1'b1;
                        else if (abs_err <= lo_lim) st_d.flag = 1'b0;
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.stage <= ST_FLUSH;
            st_q.flag  <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign req_tgl_o = st_q.req;
    assign hb_o      = st_q.win[2];
    assign flag_o    = st_q.flag;

    // No judged window yet means the flag is held high (R1)
    assert_unsettled_high_R1: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (st_q.stage != ST_RUN) |-> st_q.flag);

    // Small error in a judged window clears the flag (R2)
    assert_release_R2: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (!cfg_chg && ack_evt && st_q.stage == ST_RUN && abs_err <= lo_lim) |=> !st_q.flag);

    // Large error in a judged window sets the flag (R3)
    assert_set_R3: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (!cfg_chg && ack_evt && st_q.stage == ST_RUN && abs_err > hi_lim) |=> st_q.flag);

    // Without a judged capture or a config change the flag does not move (R4)
    assert_hold_R4: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (!cfg_chg && !ack_evt) |=> $stable(st_q.flag));

    // A config change forces the flag and restarts measurement (R8)
    assert_restart_R8: assert property (@(posedge ref_clk) disable iff (!rst_n)
        cfg_chg |=> (st_q.flag && st_q.stage == ST_FLUSH && st_q.win == '0));
endmodule

// File: rtl/lkd_freq_lock.sv
`timescale 1ps/1ps
module lkd_freq_lock #(
    parameter int BASE_WIN = 512,
    parameter int VCO_MULT = 8,
    parameter int CNT_W    = 16,
    parameter int PPM_REL  = 500,
    parameter int PPM_SET  = 1000,
    parameter int DEAD_LIM = 256
) (
    input  logic       ref_clk,
    input  logic       vco_div_clk,
    input  logic       rst_n,
    input  logic [1:0] ref_sel,
    input  logic       fec_rate,
    output logic       lock_lost,
    output logic       phase_loop_sel
);
    logic [CNT_W-1:0] hold;
    logic             ack_tgl;
    logic             req_tgl;
    logic             hb;
    logic             ref_dead;
    logic             flag;

    lkd_vco_side #(
        .CNT_W    (CNT_W),
        .DEAD_LIM (DEAD_LIM)
    ) u_vco (
        .vco_clk   (vco_div_clk),
        .rst_n     (rst_n),
        .req_tgl_i (req_tgl),
        .hb_i      (hb),
        .hold_o    (hold),
        .ack_tgl_o (ack_tgl),
        .dead_o    (ref_dead)
    );

    lkd_ref_side #(
        .BASE_WIN (BASE_WIN),
        .VCO_MULT (VCO_MULT),
        .CNT_W    (CNT_W),
        .PPM_REL  (PPM_REL),
        .PPM_SET  (PPM_SET)
    ) u_ref (
        .ref_clk   (ref_clk),
        .rst_n     (rst_n),
        .ref_sel   (ref_sel),
        .fec_rate  (fec_rate),
        .hold_i    (hold),
        .ack_tgl_i (ack_tgl),
        .req_tgl_o (req_tgl),
        .hb_o      (hb),
        .flag_o    (flag)
    );

    assign lock_lost      = flag | ref_dead;
    assign phase_loop_sel = ~lock_lost;

    // Loop selection follows the flag at the ports (R5)
    assert_loop_sel_R5: assert property (@(posedge ref_clk) disable iff (!rst_n)
        phase_loop_sel != lock_lost);
endmodule

// File: tb/lkd_freq_lock_tb.sv
`timescale 1ps/1ps
module lkd_freq_lock_tb;
    localparam int  VCO_PER  = 10000;                 // nominal divided oscillator period, ps
    localparam int  BASE_WIN = 512;
    localparam int  VCO_MULT = 8;
    localparam int  REF0_PER = VCO_PER * VCO_MULT;    // 19.44 MHz equivalent
    localparam longint WIN_T = longint'(BASE_WIN) * REF0_PER;  // window time, same for all codes
    localparam longint STEP  = (WIN_T * 21) / 10 + 7;

    logic       ref_clk = 1'b0;
    logic       vco_clk = 1'b0;
    logic       rst_n   = 1'b0;
    logic [1:0] ref_sel = 2'b00;
    logic       fec_rate = 1'b0;
    logic       lock_lost;
    logic       phase_loop_sel;

    int ref_half = REF0_PER / 2;
    int vco_half = VCO_PER / 2;
    bit ref_en   = 1'b1;
    int total = 0;
    int bad   = 0;

    lkd_freq_lock #(.BASE_WIN(BASE_WIN), .VCO_MULT(VCO_MULT)) u_dut (
        .ref_clk        (ref_clk),
        .vco_div_clk    (vco_clk),
        .rst_n          (rst_n),
        .ref_sel        (ref_sel),
        .fec_rate       (fec_rate),
        .lock_lost      (lock_lost),
        .phase_loop_sel (phase_loop_sel)
    );

    always begin
        if (ref_en) begin
            #(ref_half) ref_clk = ~ref_clk;
        end else begin
            #(1000);
        end
    end

    always #(vco_half) vco_clk = ~vco_clk;

    task automatic chk(input string req, input logic exp_lost);
        total++;
        if (lock_lost !== exp_lost) begin
            bad++;
            $display("FAIL %s: lock_lost=%0b expected %0b", req, lock_lost, exp_lost);
        end
        total++;
        if (phase_loop_sel !== ~exp_lost) begin
            bad++;
            $display("FAIL R5 (%s): phase_loop_sel=%0b expected %0b", req, phase_loop_sel, ~exp_lost);
        end
    endtask

    // Reference period for a code: REF0_PER >> code
    task automatic set_ref(input logic [1:0] code, input int per);
        ref_sel  = code;
        ref_half = per / 2;
    endtask

    initial begin : wd
        #(longint'(200000) * VCO_PER);
        total++;
        bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // Limits at defaults: native expected 4096, LO=2, HI=4; 15/14 expected 4388, LO=2, HI=4.
        #(3 * REF0_PER + 11);
        chk("R1 reset", 1'b1);
        rst_n = 1'b1;

        // R1: still high before a baseline and full window are done
        #((WIN_T * 3) / 2);
        chk("R1 first window", 1'b1);
        #((WIN_T * 6) / 10);
        chk("R2 nominal lock", 1'b0);

        // R4: 9992 ps -> count 4099/4100, error 3..4, hold low
        vco_half = 4996; #(STEP);
        chk("R4 hold low", 1'b0);
        // R3: 9980 ps -> error 8..9
        vco_half = 4990; #(STEP);
        chk("R3 fast oscillator", 1'b1);
        // R4: back in the middle band, hold high
        vco_half = 4996; #(STEP);
        chk("R4 hold high", 1'b1);
        vco_half = 5000; #(STEP);
        chk("R2 relock", 1'b0);
        // R3: slow side, 10020 ps -> error 8..9
        vco_half = 5010; #(STEP);
        chk("R3 slow oscillator", 1'b1);
        vco_half = 5000; #(STEP);
        chk("R2 relock after slow", 1'b0);

        // R6 / R8: every code with a matching reference
        for (int c = 1; c < 4; c++) begin
            set_ref(2'(c), REF0_PER >> c);
            #((WIN_T * 3) / 10);
            chk("R8 code change", 1'b1);
            #((WIN_T * 18) / 10);
            chk("R6 matching reference", 1'b0);
        end

        // R6: code 10 with the 155.52 MHz clock -> window half as long, count 2048
        set_ref(2'b10, REF0_PER >> 3);
        #(STEP);
        chk("R6 mismatched reference", 1'b1);

        // R7: 15/14 rate with a 9334 ps oscillator -> count 4388, locked
        set_ref(2'b00, REF0_PER);
        fec_rate = 1'b1;
        vco_half = 4667;
        #(STEP);
        chk("R7 fec rate lock", 1'b0);
        // R7: native oscillator under 15/14 setting -> error ~292
        vco_half = 5000; #(STEP);
        chk("R7 native under fec", 1'b1);

        // R8: back to native rate re-locks through a fresh baseline
        fec_rate = 1'b0;
        #((WIN_T * 3) / 10);
        chk("R8 rate change", 1'b1);
        #((WIN_T * 18) / 10);
        chk("R8 relock after rate change", 1'b0);

        // R9: stop the reference; oscillator-side watchdog must raise the flag
        ref_en = 1'b0;
        #(400 * VCO_PER);
        chk("R9 reference absent", 1'b1);
        ref_en = 1'b1;
        #(STEP);
        chk("R9 reference back", 1'b0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule